// File: doc/BRIEF.md
# Exception Priority Masking Filter

This block decides, one pending exception at a time, whether that exception may be taken now. It holds three masking registers: a one-bit lock that shuts out everything except the non-maskable interrupt and the hard fault, a one-bit lock that shuts out everything except the non-maskable interrupt, and a priority threshold register. The threshold register is as wide as the implemented priority field, set by a parameter of at most 8 bits. The pending exception arrives as a class code and an 8-bit priority value. The single output says whether the exception passes all three masks.

The mask registers are written and read through a small select port. Writes land on the clock edge and change the decision from the next cycle on. The decision itself is combinational from the current register contents and the current exception inputs. Arbitration among several pending exceptions, vector fetch and nesting are left to other blocks.

Class codes on `exc_class`: 0 = non-maskable interrupt, 1 = hard fault, 2 = other fault, 3 = ordinary interrupt. Register select codes on `wr_sel` / `rd_sel`: 0 = priority lock, 1 = fault lock, 2 = threshold, 3 = unused.

Top module: `exc_mask_filter`

## Requirements
- R1: After reset all three mask registers hold 0, every select reads back 0, and `take_ok` is 1 for every class and priority.
- R2: A class-0 (non-maskable interrupt) exception is always allowed, whatever the three registers hold.
- R3: While the priority lock (select 0, bit 0) is 1, class 1 (hard fault) is allowed, and classes 2 and 3 are blocked.
- R4: While the fault lock (select 1, bit 0) is 1, classes 1, 2 and 3 are all blocked.
- R5: While the threshold is nonzero, a class-2 or class-3 exception whose implemented priority bits are equal to or larger than the threshold is blocked. One with a smaller value passes that check. Classes 0 and 1 carry a fixed priority above any threshold and are never blocked by it.
- R6: A threshold of 0 blocks nothing.
- R7: Only the top PRIO_BITS bits of the threshold are stored. The lower bits read back as 0. The lower PRIO_BITS-complement bits of `exc_prio` take no part in the comparison.
- R8: A write with `wr_en` high updates the selected register on the clock edge. `take_ok` reflects the new value from the following cycle, and the cycle of the write still uses the old value.
- R9: Writes to select 3 change no register. Select 3 reads 0. The one-bit locks take `wr_data[0]` and read back in bit 0, with bits 7..1 reading 0.
- R10: `take_ok` is 1 only when all three mask checks pass at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_class | input | 2 | Class of the pending exception (0 NMI, 1 hard fault, 2 fault, 3 interrupt) |
| exc_prio | input | 8 | Priority value of the pending exception; smaller is more urgent |
| wr_en | input | 1 | Write strobe for the mask registers |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 8 | Read data of the selected register |
| take_ok | output | 1 | 1 when the pending exception may be taken |

## Verification
Each class is presented with every lock alone, so that the NMI-only lock and the NMI-plus-hard-fault lock are told apart by their handling of class 1. Priorities are swept at, one below and one above a threshold, with the unimplemented low bits set, to separate a strict from a non-strict compare and to show that the low bits are dropped. A write followed at once by an exception in the same and the next cycle pins down when a new mask value takes hold. A long stretch of mixed writes, reads and exceptions with several masks active together is compared each clock against a behavioural model.

// File: rtl/emf_pkg.sv
package emf_pkg;

    localparam int PRIO_FULL = 8;

    typedef enum logic [1:0] {
        CLS_NMI   = 2'd0,
        CLS_HARD  = 2'd1,
        CLS_FAULT = 2'd2,
        CLS_IRQ   = 2'd3
    } exc_class_e;

    typedef enum logic [1:0] {
        SEL_PRIO_LOCK  = 2'd0,
        SEL_FAULT_LOCK = 2'd1,
        SEL_THRESH     = 2'd2,
        SEL_NONE       = 2'd3
    } mask_sel_e;

endpackage

// File: rtl/emf_mask_regs.sv
module emf_mask_regs
    import emf_pkg::*;
#(
    parameter int PRIO_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [PRIO_FULL-1:0] wr_data,
    input  logic [1:0]           rd_sel,
    output logic [PRIO_FULL-1:0] rd_data,
    output logic                 prio_lock,
    output logic                 fault_lock,
    output logic [PRIO_BITS-1:0] thresh
);

    mask_sel_e wsel;
    mask_sel_e rsel;
    logic [PRIO_FULL-1:0] thresh_ext;

    assign wsel = mask_sel_e'(wr_sel);
    assign rsel = mask_sel_e'(rd_sel);

    // Register state; only the implemented top bits of the threshold are kept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_lock  <= 1'b0;
            fault_lock <= 1'b0;
            thresh     <= '0;
        end else if (wr_en) begin
            unique case (wsel)
                SEL_PRIO_LOCK:  prio_lock  <= wr_data[0];
                SEL_FAULT_LOCK: fault_lock <= wr_data[0];
                SEL_THRESH:     thresh     <= wr_data[PRIO_FULL-1 -: PRIO_BITS];
                SEL_NONE:       ;
            endcase
        end
    end

    // Left-align the stored threshold; unimplemented low bits read as zero.
    always_comb begin
        thresh_ext = '0;
        thresh_ext[PRIO_FULL-1 -: PRIO_BITS] = thresh;
    end

    always_comb begin
        unique case (rsel)
            SEL_PRIO_LOCK:  rd_data = {{(PRIO_FULL-1){1'b0}}, prio_lock};
            SEL_FAULT_LOCK: rd_data = {{(PRIO_FULL-1){1'b0}}, fault_lock};
            SEL_THRESH:     rd_data = thresh_ext;
            SEL_NONE:       rd_data = '0;
        endcase
    end

endmodule

// File: rtl/emf_thresh_cmp.sv
module emf_thresh_cmp
    import emf_pkg::*;
#(
    parameter int PRIO_BITS = 3
) (
    input  logic [PRIO_BITS-1:0] thresh,
    input  logic [PRIO_FULL-1:0] exc_prio,
    output logic                 below_thresh
);

    logic [PRIO_BITS-1:0] prio_impl;
    logic                 thresh_on;

    // Low-order bits beyond the implemented width are dropped.
    assign prio_impl = exc_prio[PRIO_FULL-1 -: PRIO_BITS];
    assign thresh_on = |thresh;

    // Passes when threshold masking is off or the exception is more urgent.
    assign below_thresh = !thresh_on || (prio_impl < thresh);

endmodule

// File: rtl/emf_class_gate.sv
module emf_class_gate
    import emf_pkg::*;
(
    input  logic [1:0] exc_class,
    input  logic       prio_lock,
    input  logic       fault_lock,
    input  logic       below_thresh,
    output logic       take_ok
);

    exc_class_e cls;
    logic pass_prio_lock;
    logic pass_fault_lock;
    logic pass_thresh;

    assign cls = exc_class_e'(exc_class);

    always_comb begin
        unique case (cls)
            CLS_NMI: begin
                pass_prio_lock  = 1'b1;
                pass_fault_lock = 1'b1;
                pass_thresh     = 1'b1;
            end
            CLS_HARD: begin
                pass_prio_lock  = 1'b1;
                pass_fault_lock = !fault_lock;
                pass_thresh     = 1'b1;
            end
            CLS_FAULT, CLS_IRQ: begin
                pass_prio_lock  = !prio_lock;
                pass_fault_lock = !fault_lock;
                pass_thresh     = below_thresh;
            end
        endcase
    end

    assign take_ok = pass_prio_lock && pass_fault_lock && pass_thresh;

endmodule

// File: rtl/exc_mask_filter.sv
module exc_mask_filter #(
    parameter int PRIO_BITS = 3   // implemented priority width, 1..8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] exc_class,
    input  logic [7:0] exc_prio,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_sel,
    output logic [7:0] rd_data,
    output logic       take_ok
);

    logic                 prio_lock_q;
    logic                 fault_lock_q;
    logic [PRIO_BITS-1:0] thresh_q;
    logic                 below_thresh;

    emf_mask_regs #(.PRIO_BITS(PRIO_BITS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data),
        .prio_lock  (prio_lock_q),
        .fault_lock (fault_lock_q),
        .thresh     (thresh_q)
    );

    emf_thresh_cmp #(.PRIO_BITS(PRIO_BITS)) u_cmp (
        .thresh       (thresh_q),
        .exc_prio     (exc_prio),
        .below_thresh (below_thresh)
    );

    emf_class_gate u_gate (
        .exc_class    (exc_class),
        .prio_lock    (prio_lock_q),
        .fault_lock   (fault_lock_q),
        .below_thresh (below_thresh),
        .take_ok      (take_ok)
    );

endmodule

// File: rtl/exc_mask_filter_chk.sv
module exc_mask_filter_chk #(
    parameter int PRIO_BITS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           exc_class,
    input logic [7:0]           exc_prio,
    input logic                 wr_en,
    input logic [1:0]           wr_sel,
    input logic [7:0]           wr_data,
    input logic [1:0]           rd_sel,
    input logic [7:0]           rd_data,
    input logic                 take_ok,
    input logic                 prio_lock_q,
    input logic                 fault_lock_q,
    input logic [PRIO_BITS-1:0] thresh_q
);

    localparam logic [7:0] LOW_MASK = 8'((1 << (8 - PRIO_BITS)) - 1);

    p_nmi_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_class == 2'd0) |-> take_ok);

    p_prio_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_lock_q && exc_class[1]) |-> !take_ok);

    p_fault_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_lock_q && exc_class != 2'd0) |-> !take_ok);

    p_thresh_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio_lock_q && !fault_lock_q && thresh_q == '0) |-> take_ok);

    p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2) |-> ((rd_data & LOW_MASK) == 8'd0));

    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (prio_lock_q == $past(wr_data[0])));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == 2'd1) |=> $stable(fault_lock_q));

    p_unused_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd3) |-> (rd_data == 8'd0));

endmodule

bind exc_mask_filter exc_mask_filter_chk #(.PRIO_BITS(PRIO_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_class    (exc_class),
    .exc_prio     (exc_prio),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_data      (wr_data),
    .rd_sel       (rd_sel),
    .rd_data      (rd_data),
    .take_ok      (take_ok),
    .prio_lock_q  (prio_lock_q),
    .fault_lock_q (fault_lock_q),
    .thresh_q     (thresh_q)
);

// File: tb/exc_mask_filter_bench.sv
module exc_mask_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PB = 3;
    localparam logic [7:0] IMPL = 8'((8'hFF << (8 - PB)) & 8'hFF);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] exc_class = 2'd0;
    logic [7:0] exc_prio = 8'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       take_ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state
    bit       m_pl = 0;
    bit       m_fl = 0;
    int       m_thr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_mask_filter #(.PRIO_BITS(PB)) u_exc_mask_filter (
        .clk(clk), .rst_n(rst_n), .exc_class(exc_class), .exc_prio(exc_prio),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .take_ok(take_ok)
    );

    function automatic bit model_allow(int cls, int prio);
        if (cls == 0) return 1;
        if (m_fl) return 0;
        if (m_pl && cls >= 2) return 0;
        if (m_thr != 0 && cls >= 2 && (prio & IMPL) >= m_thr) return 0;
        return 1;
    endfunction

    function automatic int model_read(int sel);
        case (sel)
            0: return int'(m_pl);
            1: return int'(m_fl);
            2: return m_thr;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before the edge, update model at the edge.
    task automatic cyc(string tag, int cls, int prio, bit we, int ws, int wd, int rs);
        @(negedge clk);
        exc_class = 2'(cls);
        exc_prio  = 8'(prio);
        wr_en     = we;
        wr_sel    = 2'(ws);
        wr_data   = 8'(wd);
        rd_sel    = 2'(rs);
        #1;
        check(tag, int'(take_ok), int'(model_allow(cls, prio)), "take_ok");
        check(tag, int'(rd_data), model_read(rs), "rd_data");
        @(posedge clk);
        if (we) begin
            case (ws)
                0: m_pl = wd[0];
                1: m_fl = wd[0];
                2: m_thr = wd & IMPL;
                default: ;
            endcase
        end
    endtask

    task automatic wr(string tag, int ws, int wd);
        cyc(tag, 3, 0, 1, ws, wd, ws);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < 4; c++) cyc("R1", c, 255, 0, 0, 0, c);

        // R3: priority lock keeps NMI and hard fault only
        wr("R3", 0, 1);
        for (int c = 0; c < 4; c++) cyc("R3", c, 0, 0, 0, 0, 0);
        cyc("R2", 0, 255, 0, 0, 0, 0);
        wr("R3", 0, 0);

        // R4: fault lock keeps NMI only
        wr("R4", 1, 8'hFF);
        for (int c = 0; c < 4; c++) cyc("R4", c, 0, 0, 0, 0, 1);
        cyc("R9", 1, 0, 0, 0, 0, 1);
        wr("R4", 1, 0);

        // R5/R7: threshold 0x80 with low bits in the write discarded
        wr("R7", 2, 8'h9F);
        cyc("R7", 3, 0, 0, 0, 0, 2);
        cyc("R5", 3, 8'h60, 0, 0, 0, 2);
        cyc("R5", 3, 8'h7F, 0, 0, 0, 2);
        cyc("R5", 3, 8'h80, 0, 0, 0, 2);
        cyc("R5", 2, 8'h9F, 0, 0, 0, 2);
        cyc("R5", 2, 8'hA0, 0, 0, 0, 2);
        cyc("R5", 1, 8'hFF, 0, 0, 0, 2);
        cyc("R2", 0, 8'hFF, 0, 0, 0, 2);

        // R9: unused select ignored
        wr("R9", 3, 8'hFF);
        cyc("R9", 3, 8'h80, 0, 0, 0, 2);
        cyc("R9", 3, 8'h80, 0, 0, 0, 3);

        // R6: threshold back to zero
        wr("R6", 2, 8'h1F);
        cyc("R6", 3, 8'hFF, 0, 0, 0, 2);

        // R8: write cycle uses old value, next cycle new value
        cyc("R8", 2, 8'h40, 1, 0, 1, 0);
        cyc("R8", 2, 8'h40, 0, 0, 0, 0);
        cyc("R8", 1, 8'h40, 1, 1, 1, 1);
        cyc("R8", 1, 8'h40, 0, 0, 0, 1);
        wr("R8", 0, 0);
        wr("R8", 1, 0);

        // R10: combined masks, mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            cyc("R10", r & 3, (r >> 2) & 255, ((r >> 10) & 3) == 0,
                (r >> 12) & 3, (r >> 14) & 255, (r >> 22) & 3);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule